// File: doc/BRIEF.md
# Byte SPI Master with Select Framing

This block drives a single SPI slave with 8-bit characters. A byte offered on a valid/ready input is shifted out on MOSI most significant bit first while MISO is captured, and the byte collected from the slave leaves on a one-cycle output pulse. The serial clock idles at a level chosen by `cpol`. Data is set up before the first clock edge and is sampled on the leading (idle-to-active) edge of every bit, as in clock phase 0.

The block frames every character on the active-low select line. Select goes low one full bit period before the first clock edge. It returns high one bit period after the eighth bit ends. Three further bit periods then pass before the next byte is accepted. A bit period is `2*(div+1)` clock cycles.

A sticky forced-select mode holds the select line low across any number of characters, for slaves that need select to stay active between bytes. A one-cycle `force_cs` pulse enters the mode and a one-cycle `release_cs` pulse leaves it. The framing timing stays the same in this mode; only the select line's return to high is suppressed.

Top module: `spi_cs_master`

Input handshake rules: a byte transfers in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the block is idle. A producer that sees `tx_ready` low holds `tx_valid` and `tx_data` unchanged until the transfer happens. The output side has no back-pressure: `rx_data` is valid only in the cycle `rx_valid` is high.

## Requirements
- R1: While reset is applied, and after it is released, `nss_n` is high, `sck` equals `cpol`, `tx_ready` is 1, and `busy` and `rx_valid` are 0.
- R2: With D = `div`+1, `nss_n` falls exactly 2·D cycles before the first change of `sck` away from its idle level, and `sck` is at its idle level when `nss_n` falls.
- R3: Each character is 8 bits. They go out on MOSI most significant bit first, with exactly 8 leading `sck` edges. MOSI is stable across every leading edge, so the slave samples the sent byte.
- R4: MISO is sampled on each leading edge. The assembled byte (first sampled bit as bit 7) appears on `rx_data` with a single-cycle `rx_valid` pulse 18·D cycles after `nss_n` falls.
- R5: Unless forced-select is active, `nss_n` rises exactly 2·D cycles after the `rx_valid` cycle.
- R6: `tx_ready` returns high exactly 8·D cycles after the `rx_valid` cycle. With `tx_valid` held high, `nss_n` therefore stays high for 6·D+1 cycles between two characters.
- R7: Accepting a byte makes `busy` high and `nss_n` low in the next cycle. `busy` stays high for exactly 26·D cycles, and `tx_ready` is low whenever `busy` is high.
- R8: A `force_cs` pulse (without `release_cs`) drives `nss_n` low in the next cycle. It stays low across consecutive characters and while idle afterwards.
- R9: A `release_cs` pulse ends forced-select. If no character is in progress, `nss_n` rises in the next cycle. If a character is in progress, `nss_n` rises 2·D cycles after that character's `rx_valid`.
- R10: If `force_cs` and `release_cs` are high in the same cycle, the release wins and forced-select is off afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Idle level of `sck`; change only while idle |
| div | input | DIV_W | Half-bit divider; one bit period is 2*(div+1) clocks |
| tx_valid | input | 1 | Byte offered on `tx_data` |
| tx_ready | output | 1 | Block idle and able to take a byte |
| tx_data | input | DATA_W | Byte to send |
| force_cs | input | 1 | Pulse: enter forced-select |
| release_cs | input | 1 | Pulse: leave forced-select (wins over `force_cs`) |
| rx_valid | output | 1 | One-cycle pulse, received byte on `rx_data` |
| rx_data | output | DATA_W | Received byte |
| busy | output | 1 | Character framing in progress, lead through gap |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_n | output | 1 | Active-low slave select |

## Verification
The assertions check, on every cycle, the invariants that need no timing count: the idle clock level while not busy, a stable MOSI across each leading edge, a quiet clock when select falls, single-cycle receive pulses, select high whenever idle and unforced, and the next-cycle effects of accepting a byte and of the force and release pulses, including release priority. The exact spacing of select lead, trail and gap in multiples of the divider, the bit order in both directions, and the way forced-select holds across characters and releases mid-character can only be shown by the bench's timed scenarios. The bench sweeps the divider, polarity and data patterns to cover these.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_GAP
  } spi_state_e;
endpackage

// File: rtl/spi_half_tick.sv
// Half-bit strobe generator: one tick every (div+1) clocks while running.
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || cnt_q == div)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
// Framing sequencer: lead, 8 bits, trail, gap; plus sticky forced select.
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_BITS  = 1,
  parameter int TRAIL_BITS = 1,
  parameter int GAP_BITS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       force_cs,
  input  logic       release_cs,
  output spi_state_e state,
  output logic       sck_act,
  output logic       lead_evt,
  output logic       trail_evt,
  output logic       done,
  output logic       forced,
  output logic       nss_n
);
  localparam int LEAD_H  = 2 * LEAD_BITS;
  localparam int XFER_H  = 2 * DATA_W;
  localparam int TRAIL_H = 2 * TRAIL_BITS;
  localparam int GAP_H   = 2 * GAP_BITS;
  localparam int MAX_A   = (LEAD_H > TRAIL_H) ? LEAD_H : TRAIL_H;
  localparam int MAX_B   = (XFER_H > GAP_H) ? XFER_H : GAP_H;
  localparam int MAX_H   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_W    = $clog2(MAX_H);

  localparam logic [PH_W-1:0] LEAD_LAST  = PH_W'(LEAD_H - 1);
  localparam logic [PH_W-1:0] XFER_LAST  = PH_W'(XFER_H - 1);
  localparam logic [PH_W-1:0] TRAIL_LAST = PH_W'(TRAIL_H - 1);
  localparam logic [PH_W-1:0] GAP_LAST   = PH_W'(GAP_H - 1);

  spi_state_e      state_q;
  logic [PH_W-1:0] ph_q;
  logic            sck_q;
  logic            forced_q;

  assign state   = state_q;
  assign sck_act = sck_q;
  assign forced  = forced_q;

  // Leading edges: end of lead, and each odd-to-even half inside the byte.
  assign lead_evt  = tick && ((state_q == ST_LEAD && ph_q == LEAD_LAST) ||
                              (state_q == ST_XFER && ph_q[0] && ph_q != XFER_LAST));
  assign trail_evt = tick && state_q == ST_XFER && !ph_q[0];
  assign done      = tick && state_q == ST_XFER && ph_q == XFER_LAST;

  assign nss_n = !(forced_q || state_q == ST_LEAD || state_q == ST_XFER ||
                   state_q == ST_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      forced_q <= 1'b0;
    else if (release_cs)
      forced_q <= 1'b0;
    else if (force_cs)
      forced_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      sck_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LEAD;
            ph_q    <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (ph_q == LEAD_LAST) begin
              state_q <= ST_XFER;
              ph_q    <= '0;
              sck_q   <= 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (ph_q == XFER_LAST) begin
              state_q <= ST_TRAIL;
              ph_q    <= '0;
            end else begin
              ph_q  <= ph_q + 1'b1;
              sck_q <= ~sck_q;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (ph_q == TRAIL_LAST) begin
              state_q <= ST_GAP;
              ph_q    <= '0;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (ph_q == GAP_LAST) begin
              state_q <= ST_IDLE;
              ph_q    <= '0;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
          ph_q    <= '0;
          sck_q   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
// Shared shift register: MSB out on MOSI, MISO captured on leading edges,
// shifted in on trailing edges.
module spi_byte_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lead_evt,
  input  logic              trail_evt,
  input  logic              done,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [DATA_W-1:0] sh_q;
  logic              samp_q;

  assign mosi = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      samp_q   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (load)
        sh_q <= load_data;
      else if (trail_evt)
        sh_q <= {sh_q[DATA_W-2:0], samp_q};
      if (lead_evt)
        samp_q <= miso;
      rx_valid <= done;
      if (done)
        rx_data <= sh_q;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int LEAD_BITS  = 1,
  parameter int TRAIL_BITS = 1,
  parameter int GAP_BITS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              force_cs,
  input  logic              release_cs,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              nss_n
);
  spi_state_e state;
  logic       tick, accept, sck_act, lead_evt, trail_evt, done, sel_forced;

  assign tx_ready = (state == ST_IDLE);
  assign busy     = !tx_ready;
  assign accept   = tx_valid && tx_ready;
  assign sck      = cpol ^ sck_act;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div),
    .tick (tick)
  );

  spi_cs_ctrl #(
    .DATA_W    (DATA_W),
    .LEAD_BITS (LEAD_BITS),
    .TRAIL_BITS(TRAIL_BITS),
    .GAP_BITS  (GAP_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (accept),
    .force_cs  (force_cs),
    .release_cs(release_cs),
    .state     (state),
    .sck_act   (sck_act),
    .lead_evt  (lead_evt),
    .trail_evt (trail_evt),
    .done      (done),
    .forced    (sel_forced),
    .nss_n     (nss_n)
  );

  spi_byte_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(tx_data),
    .lead_evt (lead_evt),
    .trail_evt(trail_evt),
    .done     (done),
    .miso     (miso),
    .mosi     (mosi),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic tx_valid,
  input logic tx_ready,
  input logic force_cs,
  input logic release_cs,
  input logic rx_valid,
  input logic busy,
  input logic sck,
  input logic mosi,
  input logic nss_n,
  input logic forced
);
  a_r1_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  a_r2_quiet_clock_at_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nss_n) |-> sck == cpol);

  a_r3_mosi_steady_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && sck != cpol) |-> $stable(mosi));

  a_r4_single_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r5_idle_unforced_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !forced) |-> nss_n);

  a_r7_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !nss_n));

  a_r8_force_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cs && !release_cs) |=> !nss_n);

  a_r10_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cs && release_cs) |=> !forced);
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol      (cpol),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .force_cs  (force_cs),
  .release_cs(release_cs),
  .rx_valid  (rx_valid),
  .busy      (busy),
  .sck       (sck),
  .mosi      (mosi),
  .nss_n     (nss_n),
  .forced    (sel_forced)
);

// File: tb/test_spi_cs_master.sv
`timescale 1ns/1ps
module test_spi_cs_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] div = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       force_cs = 1'b0;
  logic       release_cs = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       busy;
  logic       sck;
  logic       mosi;
  logic       miso;
  logic       nss_n;

  always #2.5 clk = ~clk;

  spi_cs_master i_spi_cs_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .div(div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .force_cs(force_cs), .release_cs(release_cs),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .nss_n(nss_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Slave model and timing monitor, sampling at the falling clock edge.
  logic [7:0] s_tx = 8'h00;
  logic [7:0] s_rx = 8'h00;
  logic [7:0] s_rx_q [2];
  logic [7:0] rv_q [2];
  int     tcnt = 0, lead_cnt = 0, rv_count = 0, rise_cnt = 0, busy_cnt = 0;
  longint fall_cyc = 0, rise_cyc = 0, first_lead = -1, rv_cyc = 0, rdy_cyc = 0;
  longint high_len = 0;
  logic   prev_sck = 1'b0, prev_nss = 1'b1, prev_rdy = 1'b1, prev_busy = 1'b0;

  assign miso = (tcnt < 8) ? s_tx[7 - tcnt] : 1'b0;

  always @(negedge clk) begin
    if (!prev_busy && busy) begin
      tcnt = 0; lead_cnt = 0; s_rx = 8'h00; first_lead = -1; busy_cnt = 0;
    end
    if (busy) busy_cnt++;
    if (sck != prev_sck) begin
      if (sck != cpol) begin
        lead_cnt++;
        s_rx = {s_rx[6:0], mosi};
        if (first_lead < 0) first_lead = cyc;
      end else begin
        tcnt++;
      end
    end
    if (prev_nss && !nss_n) begin fall_cyc = cyc; high_len = cyc - rise_cyc; end
    if (!prev_nss && nss_n) begin rise_cyc = cyc; rise_cnt++; end
    if (rx_valid) begin
      rv_cyc = cyc;
      if (rv_count < 2) begin rv_q[rv_count] = rx_data; s_rx_q[rv_count] = s_rx; end
      rv_count++;
    end
    if (!prev_rdy && tx_ready) rdy_cyc = cyc;
    prev_sck = sck; prev_nss = nss_n; prev_rdy = tx_ready; prev_busy = busy;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ready();
    do step(); while (!tx_ready);
  endtask

  // One character, single-shot, with all timing relations checked.
  task automatic one_byte(input logic [7:0] d, input logic [7:0] sb);
    longint dd;
    dd = longint'(div) + 1;
    s_tx = sb; rv_count = 0;
    tx_data = d; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    chk("R7 busy after accept", busy, 1);
    chk("R7 ready low while busy", tx_ready, 0);
    wait_ready();
    chk("R2 lead before first edge", first_lead - fall_cyc, 2 * dd);
    chk("R3 leading edge count", lead_cnt, 8);
    chk("R3 slave received byte", s_rx_q[0], d);
    chk("R4 rx pulse count", rv_count, 1);
    chk("R4 received byte", rv_q[0], sb);
    chk("R4 rx timing", rv_cyc - fall_cyc, 18 * dd);
    chk("R5 trail timing", rise_cyc - rv_cyc, 2 * dd);
    chk("R6 ready return", rdy_cyc - rv_cyc, 8 * dd);
    chk("R7 busy length", busy_cnt, 26 * dd);
  endtask

  // Two characters with tx_valid held across them.
  task automatic two_bytes(input logic [7:0] a, input logic [7:0] b);
    rv_count = 0; rise_cnt = 0; s_tx = 8'h5A;
    tx_data = a; tx_valid = 1'b1;
    step();
    tx_data = b;
    while (rv_count < 2) step();
    tx_valid = 1'b0;
    wait_ready();
    chk("R3 first byte out", s_rx_q[0], a);
    chk("R3 second byte out", s_rx_q[1], b);
    chk("R4 second byte in", rv_q[1], 8'h5A);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    // R1: reset state under both polarities.
    repeat (3) step();
    chk("R1 nss_n in reset", nss_n, 1);
    chk("R1 sck idle cpol0", sck, 0);
    chk("R1 ready in reset", tx_ready, 1);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    cpol = 1'b1;
    step();
    chk("R1 sck idle cpol1", sck, 1);
    cpol = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 nss_n after reset", nss_n, 1);
    chk("R1 ready after reset", tx_ready, 1);

    // Sweep of divider, polarity and data patterns (R2..R7).
    for (int dv = 0; dv < 4; dv++) begin
      for (int cp = 0; cp < 2; cp++) begin
        div = 8'(dv); cpol = cp[0];
        step();
        for (int k = 0; k < 4; k++) begin
          logic [7:0] d;
          d = (k == 0) ? 8'hA5 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h3C;
          one_byte(d, ~d ^ {4'(dv), 3'(k), cp[0]});
        end
      end
    end

    // R6: gap between held characters, divider 1 (D = 2).
    div = 8'd1; cpol = 1'b0;
    step();
    two_bytes(8'hC3, 8'h81);
    chk("R6 select high gap", high_len, 13);
    chk("R5 select rose per char", rise_cnt, 2);

    // R8: forced select across characters, divider 0.
    div = 8'd0;
    step();
    force_cs = 1'b1; step(); force_cs = 1'b0;
    chk("R8 select low after force", nss_n, 0);
    two_bytes(8'h12, 8'hED);
    chk("R8 no release between chars", rise_cnt, 0);
    step();
    chk("R8 still low when idle", nss_n, 0);

    // R9: release while idle.
    release_cs = 1'b1; step(); release_cs = 1'b0;
    chk("R9 idle release", nss_n, 1);

    // R9: release in the middle of a character.
    force_cs = 1'b1; step(); force_cs = 1'b0;
    rv_count = 0; tx_data = 8'h66; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    while (lead_cnt < 4) step();
    release_cs = 1'b1; step(); release_cs = 1'b0;
    chk("R9 held low mid char", nss_n, 0);
    wait_ready();
    chk("R9 rise after trail", rise_cyc - rv_cyc, 2);

    // R10: simultaneous force and release, from idle and from forced.
    force_cs = 1'b1; release_cs = 1'b1; step();
    force_cs = 1'b0; release_cs = 1'b0;
    step();
    chk("R10 release wins idle", nss_n, 1);
    force_cs = 1'b1; step(); force_cs = 1'b0;
    chk("R10 forced before", nss_n, 0);
    force_cs = 1'b1; release_cs = 1'b1; step();
    force_cs = 1'b0; release_cs = 1'b0;
    chk("R10 release wins forced", nss_n, 1);

    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule